// File: doc/BRIEF.md
# SPI status flags and interrupt requests

This block holds the four status flags of an SPI peripheral and turns them into two CPU interrupt request lines: one for the transmitter and one shared by the receiver and the error conditions. The shift engine drives it with single-cycle event pulses: a byte has arrived, transmit data has moved into the shifter, an external overrun, and a mode fault. The CPU reaches it through a small register bus with read and write strobes.

The block keeps the enable bits and applies the rules that set, clear and gate each flag. The receive-full and overflow flags clear through a two-step handshake: a status read that sees the flag set, then a read of the receive data. A write to the transmit data register clears transmitter-empty. The two request lines are gated differently by the SPI enable bit. With the mode-fault enable at 0, no mode-fault event is recorded at all.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, transmitter-empty is 1 and every other flag and every enable bit is 0. Both request lines are 0 and the status word reads 0x10.
- R2: The register map is as follows. Address 0 is status/control: read bit7 receive-full, bit6 overflow, bit5 mode-fault, bit4 transmitter-empty, bit3 error enable, bit2 mode-fault enable, bit1 receive enable, bit0 transmit enable; a write loads bits 3:0 into those enables. Address 1 is the SPI enable in bit0, read and write. Address 2 reads the receive data. Address 3 writes and reads the transmit data, which also drives `tx_byte`. Unused read bits are 0.
- R3: A receive event sets receive-full and captures `rx_byte` into the receive data register. The byte is captured on every receive event, including one that overflows.
- R4: Receive-full clears only when a status read taken while it was set is followed by a receive-data read. A receive-data read with no such record leaves it set. A write to address 0 discards the record.
- R5: If a receive event comes in the same cycle as the clearing receive-data read, receive-full stays set and overflow is not set.
- R6: Overflow sets on a receive event while receive-full is set and is not being cleared, or on an `overrun_in` pulse. It clears by the same status-read-then-data-read sequence, taken while overflow was set.
- R7: Transmitter-empty clears on a write to address 3 and sets on `tx_loaded`. If both occur in the same cycle, the write wins.
- R8: `irq_tx` is 1 exactly when transmitter-empty, the transmit enable and the SPI enable are all 1.
- R9: `irq_rxerr` is 1 when receive-full is set with the receive enable on, whatever the SPI enable is, or when overflow or mode-fault is set with the error enable on.
- R10: With the mode-fault enable at 0, a mode-fault event leaves mode-fault unchanged. With it at 1, the event sets mode-fault. A status read that sees mode-fault set, followed by a write to address 0, clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Pulse: a byte has been received |
| rx_byte | input | DATA_W | Received byte, valid with rx_done |
| tx_loaded | input | 1 | Pulse: transmit data has moved to the shifter |
| overrun_in | input | 1 | Pulse: external overrun indication |
| mode_fault_in | input | 1 | Pulse: mode fault detected |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address (combinational) |
| tx_byte | output | DATA_W | Transmit data register contents |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rxerr | output | 1 | Receiver/error interrupt request |

## Verification
The bench uses the default DATA_W of 8. With that width the status word fills the whole data bus, so every flag and enable position is visible on each status read. Random event pulses are mixed with bus operations, which reaches the same-cycle collisions: a receive event on the clearing data read, and a transmit-data write together with a shifter load. Directed steps walk through each form of the clearing handshake, including a record discarded by a control write. They also show the receiver request raised with the SPI disabled.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_RXD  = 2'd2;
  localparam logic [ADDR_W-1:0] A_TXD  = 2'd3;

  typedef struct packed {
    logic rxf;
    logic ovr;
    logic modf;
    logic txe;
  } flags_t;

  typedef struct packed {
    logic spe;
    logic errie;
    logic modfen;
    logic rxie;
    logic txie;
  } en_t;

  function automatic logic tx_req(flags_t f, en_t e);
    return f.txe & e.txie & e.spe;
  endfunction

  function automatic logic rxerr_req(flags_t f, en_t e);
    return (f.rxf & e.rxie) | ((f.ovr | f.modf) & e.errie);
  endfunction

  function automatic logic [7:0] stat_word(flags_t f, en_t e);
    return {f.rxf, f.ovr, f.modf, f.txe, e.errie, e.modfen, e.rxie, e.txie};
  endfunction
endpackage

// File: rtl/spi_flag_core.sv
module spi_flag_core
  import spi_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_evt,
  input  logic   tx_load,
  input  logic   ovr_evt,
  input  logic   mf_evt,
  input  logic   modfen,
  input  logic   stat_rd,
  input  logic   stat_wr,
  input  logic   rxd_rd,
  input  logic   txd_wr,
  output flags_t flags
);
  logic seen_rxf, seen_ovr, seen_modf;
  logic clr_rxf, clr_ovr, clr_modf;
  logic ovr_set, mf_set;

  assign clr_rxf  = rxd_rd & seen_rxf;
  assign clr_ovr  = rxd_rd & seen_ovr;
  assign clr_modf = stat_wr & seen_modf;
  assign ovr_set  = (rx_evt & flags.rxf & ~clr_rxf) | ovr_evt;
  assign mf_set   = mf_evt & modfen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '{rxf: 1'b0, ovr: 1'b0, modf: 1'b0, txe: 1'b1};
      seen_rxf  <= 1'b0;
      seen_ovr  <= 1'b0;
      seen_modf <= 1'b0;
    end else begin
      if (stat_wr) begin
        seen_rxf <= 1'b0;
        seen_ovr <= 1'b0;
      end else if (stat_rd) begin
        seen_rxf <= flags.rxf;
        seen_ovr <= flags.ovr;
      end else if (rxd_rd) begin
        seen_rxf <= 1'b0;
        seen_ovr <= 1'b0;
      end
      if (stat_rd)      seen_modf <= flags.modf;
      else if (stat_wr) seen_modf <= 1'b0;

      if (rx_evt)       flags.rxf <= 1'b1;
      else if (clr_rxf) flags.rxf <= 1'b0;
      if (ovr_set)      flags.ovr <= 1'b1;
      else if (clr_ovr) flags.ovr <= 1'b0;
      if (mf_set)        flags.modf <= 1'b1;
      else if (clr_modf) flags.modf <= 1'b0;
      if (txd_wr)       flags.txe <= 1'b0;
      else if (tx_load) flags.txe <= 1'b1;
    end
  end

  assert_txe_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txd_wr |=> !flags.txe);
  assert_rxf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.rxf && !rxd_rd) |=> flags.rxf);
  assert_rx_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> flags.rxf);
  assert_ovr_on_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && flags.rxf && !rxd_rd) |=> flags.ovr);
  assert_modf_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!modfen && !flags.modf) |=> !flags.modf);
endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen
  import spi_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t flags,
  input  en_t    en,
  output logic   irq_tx,
  output logic   irq_rxerr
);
  assign irq_tx    = tx_req(flags, en);
  assign irq_rxerr = rxerr_req(flags, en);

  assert_tx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en.spe |-> !irq_tx);
  assert_rx_any_spe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.rxf && en.rxie) |-> irq_rxerr);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en.errie && !(flags.rxf && en.rxie)) |-> !irq_rxerr);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_loaded,
  input  logic              overrun_in,
  input  logic              mode_fault_in,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] tx_byte,
  output logic              irq_tx,
  output logic              irq_rxerr
);
  flags_t flags;
  en_t    en;
  logic [DATA_W-1:0] rxd_q, txd_q;
  logic stat_rd, stat_wr, ctrl_wr, rxd_rd, txd_wr;

  assign stat_rd = bus_rd & (bus_addr == A_STAT);
  assign stat_wr = bus_wr & (bus_addr == A_STAT);
  assign ctrl_wr = bus_wr & (bus_addr == A_CTRL);
  assign rxd_rd  = bus_rd & (bus_addr == A_RXD);
  assign txd_wr  = bus_wr & (bus_addr == A_TXD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= '0;
      rxd_q <= '0;
      txd_q <= '0;
    end else begin
      if (stat_wr) begin
        en.errie  <= bus_wdata[3];
        en.modfen <= bus_wdata[2];
        en.rxie   <= bus_wdata[1];
        en.txie   <= bus_wdata[0];
      end
      if (ctrl_wr) en.spe <= bus_wdata[0];
      if (rx_done) rxd_q <= rx_byte;
      if (txd_wr)  txd_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_STAT:  bus_rdata[7:0] = stat_word(flags, en);
      A_CTRL:  bus_rdata[0]   = en.spe;
      A_RXD:   bus_rdata      = rxd_q;
      default: bus_rdata      = txd_q;
    endcase
  end

  assign tx_byte = txd_q;

  spi_flag_core u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_evt  (rx_done),
    .tx_load (tx_loaded),
    .ovr_evt (overrun_in),
    .mf_evt  (mode_fault_in),
    .modfen  (en.modfen),
    .stat_rd (stat_rd),
    .stat_wr (stat_wr),
    .rxd_rd  (rxd_rd),
    .txd_wr  (txd_wr),
    .flags   (flags)
  );

  spi_irq_gen u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .en        (en),
    .irq_tx    (irq_tx),
    .irq_rxerr (irq_rxerr)
  );

  assert_rxd_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (rxd_q == $past(rx_byte)));
  assert_txd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_wr |=> $stable(tx_byte));
endmodule

// File: tb/spi_irq_status_bench.sv
`timescale 1ns/1ps
module spi_irq_status_bench;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, tx_loaded = 0, overrun_in = 0, mode_fault_in = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [DW-1:0] rx_byte = 0, bus_wdata = 0;
  logic [DW-1:0] bus_rdata, tx_byte;
  logic irq_tx, irq_rxerr;

  always #10 clk = ~clk;

  spi_irq_status #(.DATA_W(DW)) u_spi_irq_status (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .tx_loaded(tx_loaded), .overrun_in(overrun_in), .mode_fault_in(mode_fault_in),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_byte(tx_byte), .irq_tx(irq_tx), .irq_rxerr(irq_rxerr)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench-side model
  bit m_rxf, m_ovr, m_modf, m_txe;
  bit m_spe, m_errie, m_modfen, m_rxie, m_txie;
  bit k_rxf, k_ovr, k_modf;
  logic [7:0] m_rxd, m_txd;

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return {m_rxf, m_ovr, m_modf, m_txe, m_errie, m_modfen, m_rxie, m_txie};
      2'd1: return {7'd0, m_spe};
      2'd2: return m_rxd;
      default: return m_txd;
    endcase
  endfunction

  function automatic bit exp_tx();
    return m_spe && m_txie && m_txe;
  endfunction

  function automatic bit exp_rxerr();
    if (m_rxie && m_rxf) return 1;
    if (m_errie && (m_ovr || m_modf)) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rxf = 0; m_ovr = 0; m_modf = 0; m_txe = 1;
    m_spe = 0; m_errie = 0; m_modfen = 0; m_rxie = 0; m_txie = 0;
    k_rxf = 0; k_ovr = 0; k_modf = 0; m_rxd = 0; m_txd = 0;
  endtask

  task automatic model_step(bit rxe, bit txl, bit ove, bit mfe, bit rd, bit wr,
                            logic [1:0] a, logic [7:0] wd, logic [7:0] rb);
    bit srd, swr, drd, twr, rx_gone, ovr_gone, mf_gone;
    srd = rd && a == 0; swr = wr && a == 0; drd = rd && a == 2; twr = wr && a == 3;
    rx_gone = drd && k_rxf; ovr_gone = drd && k_ovr; mf_gone = swr && k_modf;
    // overflow: new byte on a full, not-just-emptied receiver, or external pulse
    if ((rxe && m_rxf && !rx_gone) || ove) m_ovr = 1; else if (ovr_gone) m_ovr = 0;
    if (rxe) m_rxf = 1; else if (rx_gone) m_rxf = 0;
    if (mfe && m_modfen) m_modf = 1; else if (mf_gone) m_modf = 0;
    if (twr) m_txe = 0; else if (txl) m_txe = 1;
    if (srd) begin k_rxf = m_rxf_prev; k_ovr = m_ovr_prev; k_modf = m_modf_prev; end
    else begin
      if (swr || drd) begin k_rxf = 0; k_ovr = 0; end
      if (swr) k_modf = 0;
    end
    if (swr) {m_errie, m_modfen, m_rxie, m_txie} = wd[3:0];
    if (wr && a == 1) m_spe = wd[0];
    if (rxe) m_rxd = rb;
    if (twr) m_txd = wd;
  endtask

  bit m_rxf_prev, m_ovr_prev, m_modf_prev;

  task automatic step(string tag, bit rxe, bit txl, bit ove, bit mfe, bit rd, bit wr,
                      logic [1:0] a, logic [7:0] wd, logic [7:0] rb);
    rx_done = rxe; tx_loaded = txl; overrun_in = ove; mode_fault_in = mfe;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; rx_byte = rb;
    #1;
    if (rd) chk({tag, " read"}, bus_rdata, exp_read(a));
    m_rxf_prev = m_rxf; m_ovr_prev = m_ovr; m_modf_prev = m_modf;
    @(posedge clk);
    model_step(rxe, txl, ove, mfe, rd, wr, a, wd, rb);
    @(negedge clk);
    rx_done = 0; tx_loaded = 0; overrun_in = 0; mode_fault_in = 0; bus_rd = 0; bus_wr = 0;
    chk({tag, " irq_tx"}, {7'd0, irq_tx}, {7'd0, exp_tx()});
    chk({tag, " irq_rxerr"}, {7'd0, irq_rxerr}, {7'd0, exp_rxerr()});
    chk({tag, " tx_byte"}, tx_byte, m_txd);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(string tag, logic [1:0] a);
    step(tag, 0, 0, 0, 0, 1, 0, a, 0, 0);
  endtask
  task automatic wr_reg(string tag, logic [1:0] a, logic [7:0] d);
    step(tag, 0, 0, 0, 0, 0, 1, a, d, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, fixed values
    chk("R1 irq_tx", {7'd0, irq_tx}, 8'd0);
    chk("R1 irq_rxerr", {7'd0, irq_rxerr}, 8'd0);
    bus_addr = 0; #1; chk("R1 status", bus_rdata, 8'h10);
    rd_reg("R1", 2'd2);
    // R2 map, R8 transmitter gating
    wr_reg("R2 spe", 2'd1, 8'h01);
    rd_reg("R2 ctrl", 2'd1);
    wr_reg("R8 txie", 2'd0, 8'h01);
    chk("R8 tx on", {7'd0, irq_tx}, 8'd1);
    wr_reg("R7 txd", 2'd3, 8'hA5);
    chk("R7 txe clear", {7'd0, irq_tx}, 8'd0);
    rd_reg("R2 txd", 2'd3);
    step("R7 load", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 txe set", {7'd0, irq_tx}, 8'd1);
    step("R7 collide", 0, 1, 0, 0, 0, 1, 2'd3, 8'h5A, 0);
    chk("R7 write wins", {7'd0, irq_tx}, 8'd0);
    step("R7 load2", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    wr_reg("R8 spe off", 2'd1, 8'h00);
    chk("R8 spe gate", {7'd0, irq_tx}, 8'd0);
    // R9 receive request with SPI disabled, R3 capture
    wr_reg("R9 rxie", 2'd0, 8'h02);
    step("R3 rx", 1, 0, 0, 0, 0, 0, 0, 0, 8'h3C);
    chk("R9 rx irq no spe", {7'd0, irq_rxerr}, 8'd1);
    rd_reg("R3 rxd", 2'd2);
    rd_reg("R4 no record", 2'd0);  // record set here...
    wr_reg("R4 drop", 2'd0, 8'h02); // ...and discarded here
    rd_reg("R4 data", 2'd2);
    bus_addr = 0; #1; chk("R4 still full", bus_rdata[7:0] & 8'h80, 8'h80);
    rd_reg("R4 stat", 2'd0);
    rd_reg("R4 clear", 2'd2);
    bus_addr = 0; #1; chk("R4 cleared", bus_rdata[7:0] & 8'h80, 8'h00);
    // R5 collision
    step("R5 rx", 1, 0, 0, 0, 0, 0, 0, 0, 8'h11);
    rd_reg("R5 stat", 2'd0);
    step("R5 collide", 1, 0, 0, 0, 1, 0, 2'd2, 0, 8'h22);
    bus_addr = 0; #1; chk("R5 kept no ovr", bus_rdata[7:0] & 8'hC0, 8'h80);
    // R6 overflow and its clear
    step("R6 rx over", 1, 0, 0, 0, 0, 0, 0, 0, 8'h33);
    bus_addr = 0; #1; chk("R6 ovr set", bus_rdata[7:0] & 8'hC0, 8'hC0);
    rd_reg("R6 stat", 2'd0);
    rd_reg("R6 data", 2'd2);
    bus_addr = 0; #1; chk("R6 both clear", bus_rdata[7:0] & 8'hC0, 8'h00);
    step("R6 ext", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd_reg("R6 stat2", 2'd0);
    rd_reg("R6 data2", 2'd2);
    // R10 mode fault enable and clear
    wr_reg("R10 errie", 2'd0, 8'h08);
    step("R10 blocked", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R10 no modf", {7'd0, irq_rxerr}, 8'd0);
    wr_reg("R10 modfen", 2'd0, 8'h0C);
    step("R10 fault", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R10 modf irq", {7'd0, irq_rxerr}, 8'd1);
    rd_reg("R10 stat", 2'd0);
    wr_reg("R10 clear", 2'd0, 8'h0C);
    chk("R10 modf cleared", {7'd0, irq_rxerr}, 8'd0);
    // random mix
    begin
      int unsigned seed;
      seed = $urandom(32'h5A17);
      for (int i = 0; i < 3000; i++) begin
        bit rxe, txl, ove, mfe, rd, wr;
        int unsigned op;
        rxe = ($urandom % 5) == 0; txl = ($urandom % 4) == 0;
        ove = ($urandom % 40) == 0; mfe = ($urandom % 12) == 0;
        op = $urandom % 6; rd = op < 3; wr = op == 3 || op == 4;
        step("R3 R4 R6 R9 random", rxe, txl, ove, mfe, rd, wr,
             2'($urandom % 4), 8'($urandom), 8'($urandom));
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule